// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor with Parallel Load

This block adds or subtracts two small unsigned operands with one full adder, working one bit pair per clock. A load pulse copies both operands into two right-shift registers in a single cycle and latches the operation mode. Each later cycle with shift enabled handles one bit position, starting at the least significant bit. A carry flip-flop passes the carry from one position to the next. The sum bit enters the operand A register at its top end, so A is replaced by the result bit by bit. The operand B register rotates, so B is back in its original form when the operation ends.

Subtraction adds the two's complement of B. In subtract mode each B bit is inverted on its way into the adder, and the carry flip-flop starts at 1. After the last bit position a done flag rises and further shift requests are ignored until the next load. The final carry reads as carry-out for an addition and as not-borrow for a subtraction.

Control pins are plain level inputs with no handshake. A load is accepted in any cycle and never stalls. A shift request is accepted in any cycle before done and is dropped while done is high. The result, the B register and the flags are outputs taken straight from registers.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous reset sets result_o, b_o, carry_o and done_o to 0 on the next clock edge.
- R2: A load takes one clock. After the edge, result_o equals a_i, b_o equals b_i and done_o is 0.
- R3: When load_i and shift_i are both high, the load is performed and the shift is not. The operation restarts and needs the full WIDTH shifts again.
- R4: With sub_i=0 at load, after WIDTH accepted shifts result_o equals (A+B) mod 2^WIDTH, and carry_o equals bit WIDTH of A+B.
- R5: With sub_i=1 at load, after WIDTH accepted shifts result_o equals (A-B) mod 2^WIDTH, and carry_o is 1 exactly when A >= B as unsigned numbers.
- R6: done_o rises on the edge of the WIDTH-th accepted shift and not earlier. A cycle with shift_i low leaves all outputs unchanged.
- R7: While done_o is high, shift_i has no effect: result_o, b_o, carry_o and done_o keep their values until a load or a reset.
- R8: When done_o rises, b_o again equals the B operand that was loaded.
- R9: Bits are handled least significant first. After k accepted shifts, result_o holds the k low bits of the final result in its top k positions, above A shifted right by k.
- R10: The mode is captured at load. Changing sub_i during the shifts does not change the result or the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load both operands and latch the mode; has priority over shift_i |
| shift_i | input | 1 | Process one bit position; ignored while done_o is high |
| sub_i | input | 1 | Mode at load: 0 adds, 1 subtracts |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Operand A register, which becomes the result |
| b_o | output | WIDTH | Operand B register, rotating |
| carry_o | output | 1 | Carry flip-flop: carry-out when adding, not-borrow when subtracting |
| done_o | output | 1 | High after WIDTH shifts, until the next load |

## Verification
Load and shift can both be requested in the same cycle. Load must win, and it must also clear a half-finished sequence. The bench provokes this by asserting load_i and shift_i together with new operands after two shifts of an earlier operation. It then checks that the registers hold the new operands, that done_o is low, and that exactly WIDTH further shifts produce the new operands' result. Nothing from the abandoned operation should appear in the scoreboard. Reset in the middle of an operation, and shift requests arriving while done_o is high, are judged in the same way at the output registers.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_mode_e;
endpackage

// File: rtl/addsub_shreg.sv
module addsub_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  // One flop per bit; the top bit takes the serial input on a step.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic shift_src;
    if (i == WIDTH - 1) begin : g_top
      assign shift_src = ser_in;
    end else begin : g_mid
      assign shift_src = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)       q[i] <= 1'b0;
      else if (load) q[i] <= load_val[i];
      else if (step) q[i] <= shift_src;
    end
  end
endmodule

// File: rtl/addsub_bit_alu.sv
module addsub_bit_alu
  import addsub_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sub_i,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry_q
);
  op_mode_e mode_q;
  logic     b_eff;
  logic     carry_next;

  assign b_eff      = (mode_q == OP_SUB) ? ~b_bit : b_bit;
  assign sum_bit    = a_bit ^ b_eff ^ carry_q;
  assign carry_next = (a_bit & b_eff) | (a_bit & carry_q) | (b_eff & carry_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= OP_ADD;
      carry_q <= 1'b0;
    end else if (load) begin
      mode_q  <= op_mode_e'(sub_i);
      carry_q <= sub_i;  // the +1 of the two's complement enters here
    end else if (step) begin
      carry_q <= carry_next;
    end
  end

  // Mode changes only at load.
  assert_mode_latched_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mode_q));
  // The carry starts at 0 for add and at 1 for subtract.
  assert_carry_preset_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (carry_q == $past(sub_i)));
endmodule

// File: rtl/addsub_seq.sv
module addsub_seq #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic shift,
  output logic step,
  output logic done
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  assign step = shift & ~load & ~done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  assert_idle_count_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> ($stable(cnt) && $stable(done)));
  assert_done_count_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cnt == '0));
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] b_o,
  output logic             carry_o,
  output logic             done_o
);
  logic step;
  logic sum_bit;

  addsub_seq #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .load  (load_i),
    .shift (shift_i),
    .step  (step),
    .done  (done_o)
  );

  addsub_bit_alu u_alu (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .sub_i   (sub_i),
    .step    (step),
    .a_bit   (result_o[0]),
    .b_bit   (b_o[0]),
    .sum_bit (sum_bit),
    .carry_q (carry_o)
  );

  // The A register fills with sum bits from the top.
  addsub_shreg #(.WIDTH(WIDTH)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .load_val (a_i),
    .step     (step),
    .ser_in   (sum_bit),
    .q        (result_o)
  );

  // The B register feeds its own low bit back into its top: it rotates.
  addsub_shreg #(.WIDTH(WIDTH)) u_breg (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .load_val (b_i),
    .step     (step),
    .ser_in   (b_o[0]),
    .q        (b_o)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && b_o == '0 && !carry_o && !done_o));
  assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (result_o == $past(a_i) && b_o == $past(b_i) && !done_o));
  assert_load_beats_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (load_i && shift_i) |=> (!done_o && result_o == $past(a_i)));
  assert_done_freezes_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !load_i) |=> (done_o && $stable(result_o) && $stable(b_o) && $stable(carry_o)));
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !shift_i) |=> ($stable(result_o) && $stable(b_o) && $stable(carry_o)));
endmodule

// File: tb/test_serial_addsub.sv
module test_serial_addsub;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  typedef struct {
    int res;
    int cy;
    int b;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 1'b0, shift_i = 1'b0, sub_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o, b_o;
  logic carry_o, done_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  serial_addsub #(.WIDTH(W)) i_serial_addsub (
    .clk(clk), .rst(rst), .load_i(load_i), .shift_i(shift_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .b_o(b_o),
    .carry_o(carry_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input int a, input int b, input bit sub);
    exp_t e;
    int full;
    full = sub ? (a + ((~b) & M) + 1) : (a + b);
    e.res = full & M;
    e.cy  = (full >> W) & 1;
    e.b   = b;
    return e;
  endfunction

  // Monitor: compare each completed operation with the scoreboard.
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst && done_o && !prev_done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(result_o) == e.res, "R4/R5 result", int'(result_o), e.res);
        chk(int'(carry_o) == e.cy, "R4/R5 carry", int'(carry_o), e.cy);
        chk(int'(b_o) == e.b, "R8 B restored", int'(b_o), e.b);
      end
    end
    prev_done = done_o;
  end

  task automatic load_op(input int a, input int b, input bit sub, input bit with_shift);
    @(negedge clk);
    load_i = 1'b1; shift_i = with_shift; sub_i = sub;
    a_i = W'(a); b_i = W'(b);
    @(negedge clk);
    load_i = 1'b0; shift_i = 1'b0;
  endtask

  // Complete operation; flip sub_i after load to probe R10.
  task automatic run_op(input int a, input int b, input bit sub, input bit flip, input int gap);
    sb.push_back(model(a, b, sub));
    load_op(a, b, sub, 1'b0);
    if (flip) sub_i = ~sub;
    for (int k = 0; k < W; k++) begin
      shift_i = 1'b1;
      @(negedge clk);
      shift_i = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(done_o == (k == W - 1), "R6 done during gap", int'(done_o), int'(k == W - 1));
      end
    end
    shift_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result_o == '0 && b_o == '0, "R1 reset regs", int'(result_o), 0);
    chk(!carry_o && !done_o, "R1 reset flags", int'({carry_o, done_o}), 0);
    rst = 1'b0;

    // R2: load in one cycle
    load_op(9, 6, 1'b0, 1'b0);
    chk(int'(result_o) == 9 && int'(b_o) == 6, "R2 load value", int'(result_o), 9);
    chk(!done_o, "R2 done low after load", int'(done_o), 0);
    sb.delete();

    // R9 and R6: per-step contents, least significant bit first
    for (int t = 0; t < 4; t++) begin
      int a, b, ex, part;
      bit sub;
      exp_t e;
      a = (t * 7 + 5) & M; b = (t * 11 + 3) & M; sub = t[0];
      e = model(a, b, sub);
      sb.push_back(e);
      load_op(a, b, sub, 1'b0);
      for (int k = 1; k <= W; k++) begin
        shift_i = 1'b1;
        @(negedge clk);
        shift_i = 1'b0;
        part = e.res & ((1 << k) - 1);
        ex = ((part << (W - k)) | (a >> k)) & M;
        chk(int'(result_o) == ex, "R9 partial result", int'(result_o), ex);
        chk(done_o == (k == W), "R6 done timing", int'(done_o), int'(k == W));
      end
    end

    // R7: shifts after done are ignored
    run_op(12, 7, 1'b0, 1'b0, 0);
    shift_i = 1'b1;
    repeat (3) @(negedge clk);
    shift_i = 1'b0;
    chk(int'(result_o) == 3 && carry_o && done_o, "R7 hold after done", int'(result_o), 3);
    chk(int'(b_o) == 7, "R7 B held", int'(b_o), 7);

    // R6: idle gaps between shifts
    run_op(5, 10, 1'b1, 1'b0, 2);
    run_op(15, 15, 1'b0, 1'b0, 1);

    // R3: load and shift together mid-operation
    load_op(3, 4, 1'b0, 1'b0);
    shift_i = 1'b1;
    repeat (2) @(negedge clk);
    sb.push_back(model(11, 2, 1'b1));
    load_i = 1'b1; sub_i = 1'b1; a_i = 4'd11; b_i = 4'd2;
    @(negedge clk);
    load_i = 1'b0; shift_i = 1'b0;
    chk(int'(result_o) == 11 && int'(b_o) == 2, "R3 load wins", int'(result_o), 11);
    chk(!done_o, "R3 sequence restarted", int'(done_o), 0);
    shift_i = 1'b1;
    repeat (W - 1) @(negedge clk);
    chk(!done_o, "R3 needs full count", int'(done_o), 0);
    @(negedge clk);
    shift_i = 1'b0;
    chk(done_o && int'(result_o) == 9, "R3 new result", int'(result_o), 9);

    // R1: reset in the middle of an operation
    load_op(6, 6, 1'b1, 1'b0);
    shift_i = 1'b1;
    @(negedge clk);
    shift_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(result_o == '0 && b_o == '0 && !carry_o && !done_o, "R1 mid-op reset",
        int'(result_o), 0);

    // R4, R5, R10: every operand pair in both modes, mode input flipped on odd A
    for (int a = 0; a <= M; a++)
      for (int b = 0; b <= M; b++)
        for (int s = 0; s < 2; s++)
          run_op(a, b, s[0], a[0], 0);

    @(negedge clk);
    @(negedge clk);
    chk(sb.size() == 0, "R6 all operations completed", sb.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule